// File: doc/BRIEF.md
# Reset Filter and Restart Sequencer

This block sits between the reset sources of a small 8-bit microcontroller and its core. It samples an active-low reset pin through a two-flop synchronizer and accepts a pin reset only after the pin has read low for four consecutive clocks. Shorter dips are discarded. Power-on, watchdog and stop-mode-recovery requests bypass that filter. Every accepted source starts the same internal reset cycle. The cycle lasts at least eighteen clocks, and it is stretched further while the pin stays low.

Power-on and watchdog resets also assert an enable that pulls the shared reset pin low for a configurable power-on interval. While that enable is set, the block ignores its own pin sample, so it cannot hold itself in reset. During reset the data strobe is held low and the address strobe toggles every clock. A fixed number of clocks after release, the block issues a one-clock start pulse and presents the restart vector to the core.

Top module: `rstseq_top`

## Requirements
- R1: A pin low for at most 3 consecutive sampling edges never asserts `core_rst`, `pin_drive_en` or `start_pulse`.
- R2: When the pin is low for 4 or more consecutive edges, `core_rst` becomes 1 immediately after the 7th rising edge, counted from the first edge that samples the pin low (2 synchronizer stages, 4 filter counts, 1 latch).
- R3: A pin reset keeps `core_rst` at 1 for max(18, K-4) cycles, where K is the number of edges on which the pin was low. In other words, it releases on the third edge after the pin returns high, but never before 18 cycles have passed.
- R4: `ds_lvl` is 0 in every cycle where `core_rst` is 1, and 1 in every other cycle.
- R5: `as_lvl` is 0 in the first cycle of a reset and inverts on every following reset cycle. It is 1 whenever `core_rst` is 0.
- R6: `start_pulse` is exactly one cycle wide. It is set in the 6th cycle after the edge that clears `core_rst` (parameter `START_DLY`, 2 or more).
- R7: `start_addr` reads 0x00C from the start pulse until `core_rst` next rises. It reads 0 from a reset until the following start pulse.
- R8: A `por_req` or `wdt_req` sampled high sets `core_rst` and `pin_drive_en` on that edge. `pin_drive_en` stays 1 for `POR_CYC` cycles. `core_rst` stays 1 for max(`POR_CYC`, 18) cycles.
- R9: A `smr_req` sampled high starts an 18-cycle reset without asserting `pin_drive_en`.
- R10: While `pin_drive_en` is 1, a low pin sample is ignored. A pin that reads low only because of the block's own drive never causes a second reset.
- R11: An internal request that arrives during an active reset restarts the 18-cycle minimum from that edge.
- R12: With `rst` high, the outputs are idle: `core_rst`=0, `pin_drive_en`=0, `ds_lvl`=1, `as_lvl`=1, `start_pulse`=0, `start_addr`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset of the sequencer itself |
| ext_rst_n | input | 1 | Sample of the reset pin, active low |
| por_req | input | 1 | Power-on reset request |
| wdt_req | input | 1 | Watchdog timeout request |
| smr_req | input | 1 | Stop-mode recovery reset request |
| core_rst | output | 1 | Internal reset to the core, active high |
| pin_drive_en | output | 1 | Enable for the open-drain pull-down on the reset pin |
| ds_lvl | output | 1 | Data strobe level |
| as_lvl | output | 1 | Address strobe level |
| start_pulse | output | 1 | One-cycle start-execution pulse |
| start_addr | output | 12 | Restart address, valid from the start pulse onward |

## Verification
A filter counter that is off by one moves the rise of `core_rst` by a cycle, or lets a 3-edge dip through. Both show up within eight clocks of the first low sample. A wrong hold or drive counter changes how long `core_rst` or `pin_drive_en` stays high, and it appears at the release edge. A stale restart delay shifts `start_pulse` or `start_addr` within a few cycles of release. The bench sweeps every pin pulse length from 1 to 30 clocks and runs each internal source, comparing the exact cycle of every edge against arithmetic from the requirements.

// File: rtl/rstseq_pkg.sv
package rstseq_pkg;

    // Internal (unfiltered) reset requests.
    typedef struct packed {
        logic por;
        logic wdt;
        logic smr;
    } int_src_t;

    // Width of a counter that must hold values 0..maxval.
    function automatic int unsigned cnt_w(input int unsigned maxval);
        return (maxval < 2) ? 1 : $clog2(maxval + 1);
    endfunction

endpackage

// File: rtl/rstseq_filter.sv
module rstseq_filter
    import rstseq_pkg::*;
#(
    parameter int unsigned FILT_LEN    = 4,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pin_n,
    input  logic mask,
    output logic pin_low,
    output logic qualified
);
    localparam int unsigned CW = cnt_w(FILT_LEN);

    logic [SYNC_STAGES-1:0] sync_q;
    logic [CW-1:0]          run_q;

    always_ff @(posedge clk) begin
        if (rst) sync_q <= '1;
        else     sync_q <= {sync_q[SYNC_STAGES-2:0], pin_n};
    end

    // Own pull-down masks the sample so the block cannot lock itself.
    assign pin_low = ~sync_q[SYNC_STAGES-1] & ~mask;

    always_ff @(posedge clk) begin
        if (rst || !pin_low)            run_q <= '0;
        else if (run_q != CW'(FILT_LEN)) run_q <= run_q + 1'b1;
    end

    assign qualified = (run_q == CW'(FILT_LEN));

    // R10: a masked sample never advances the run counter
    a_r10_mask_clears: assert property (@(posedge clk) disable iff (rst)
        mask |=> (run_q == '0));

endmodule

// File: rtl/rstseq_hold.sv
module rstseq_hold
    import rstseq_pkg::*;
#(
    parameter int unsigned MIN_HOLD = 18,
    parameter int unsigned POR_CYC  = 60000
) (
    input  logic     clk,
    input  logic     rst,
    input  int_src_t src,
    input  logic     ext_qual,
    input  logic     ext_low,
    output logic     core_rst,
    output logic     drive_en
);
    localparam int unsigned HW = cnt_w(MIN_HOLD);
    localparam int unsigned DW = cnt_w(POR_CYC);

    logic          active_q;
    logic [HW-1:0] hold_q;
    logic [DW-1:0] drv_q;
    logic          src_hit, drv_hit, may_release;

    assign src_hit     = src.por | src.wdt | src.smr;
    assign drv_hit     = src.por | src.wdt;
    assign may_release = (hold_q >= HW'(MIN_HOLD)) && !ext_low && (drv_q <= DW'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            drv_q <= '0;
        end else if (drv_hit) begin
            drv_q <= DW'(POR_CYC);
        end else if (drv_q != '0) begin
            drv_q <= drv_q - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            active_q <= 1'b0;
            hold_q   <= '0;
        end else if (src_hit || (!active_q && ext_qual)) begin
            active_q <= 1'b1;
            hold_q   <= HW'(1);
        end else if (active_q) begin
            if (may_release)                   active_q <= 1'b0;
            else if (hold_q != HW'(MIN_HOLD)) hold_q   <= hold_q + 1'b1;
        end
    end

    assign core_rst = active_q;
    assign drive_en = (drv_q != '0);

    // R3: reset never ends before the minimum length
    a_r3_min_len: assert property (@(posedge clk) disable iff (rst)
        $fell(active_q) |-> ($past(hold_q) >= HW'(MIN_HOLD)));

    // R8: pin drive only while the core is in reset
    a_r8_drive_inside: assert property (@(posedge clk) disable iff (rst)
        drive_en |-> active_q);

    // R11: an internal request always leaves the block in reset
    a_r11_src_latch: assert property (@(posedge clk) disable iff (rst)
        src_hit |=> active_q);

endmodule

// File: rtl/rstseq_restart.sv
module rstseq_restart
    import rstseq_pkg::*;
#(
    parameter int unsigned START_DLY = 6,
    parameter int unsigned ADDR_W    = 12,
    parameter logic [ADDR_W-1:0] VEC = 12'h00C
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              core_rst,
    output logic              ds_lvl,
    output logic              as_lvl,
    output logic              start_pulse,
    output logic [ADDR_W-1:0] start_addr
);
    localparam int unsigned DLW = cnt_w(START_DLY);

    logic           core_q, tog_q, pend_q, pulse_q, valid_q;
    logic [DLW-1:0] dly_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            core_q  <= 1'b0;
            tog_q   <= 1'b0;
            pend_q  <= 1'b0;
            pulse_q <= 1'b0;
            valid_q <= 1'b0;
            dly_q   <= '0;
        end else begin
            core_q  <= core_rst;
            tog_q   <= core_rst ? ~tog_q : 1'b0;
            pulse_q <= 1'b0;
            if (core_rst) begin
                pend_q  <= 1'b0;
                valid_q <= 1'b0;
            end else if (core_q) begin
                pend_q <= 1'b1;
                dly_q  <= DLW'(START_DLY - 1);
            end else if (pend_q) begin
                if (dly_q == DLW'(1)) begin
                    pend_q  <= 1'b0;
                    pulse_q <= 1'b1;
                    valid_q <= 1'b1;
                end else begin
                    dly_q <= dly_q - 1'b1;
                end
            end
        end
    end

    assign ds_lvl      = ~core_rst;
    assign as_lvl      = core_rst ? tog_q : 1'b1;
    assign start_pulse = pulse_q;
    assign start_addr  = (valid_q && !core_rst) ? VEC : '0;

    // R6: start pulse is a single cycle
    a_r6_single: assert property (@(posedge clk) disable iff (rst)
        start_pulse |=> !start_pulse);

    // R6: start pulse sits a fixed distance after release
    a_r6_delay: assert property (@(posedge clk) disable iff (rst)
        $rose(start_pulse) |-> ($past(core_rst, START_DLY + 1) && !$past(core_rst, START_DLY)));

    // R5: address strobe alternates during reset
    a_r5_toggle: assert property (@(posedge clk) disable iff (rst)
        (core_rst && $past(core_rst)) |-> (as_lvl != $past(as_lvl)));

    // R7: restart address only moves at a pulse or a new reset
    a_r7_stable: assert property (@(posedge clk) disable iff (rst)
        (!core_rst && !start_pulse) |-> $stable(start_addr));

endmodule

// File: rtl/rstseq_top.sv
module rstseq_top
    import rstseq_pkg::*;
#(
    parameter int unsigned FILT_LEN  = 4,
    parameter int unsigned MIN_HOLD  = 18,
    parameter int unsigned POR_CYC   = 60000,
    parameter int unsigned START_DLY = 6,
    parameter int unsigned ADDR_W    = 12,
    parameter logic [ADDR_W-1:0] VEC = 12'h00C
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ext_rst_n,
    input  logic              por_req,
    input  logic              wdt_req,
    input  logic              smr_req,
    output logic              core_rst,
    output logic              pin_drive_en,
    output logic              ds_lvl,
    output logic              as_lvl,
    output logic              start_pulse,
    output logic [ADDR_W-1:0] start_addr
);
    int_src_t src;
    logic     ext_low, ext_qual;

    assign src = '{por: por_req, wdt: wdt_req, smr: smr_req};

    rstseq_filter #(.FILT_LEN(FILT_LEN), .SYNC_STAGES(2)) u_filter (
        .clk       (clk),
        .rst       (rst),
        .pin_n     (ext_rst_n),
        .mask      (pin_drive_en),
        .pin_low   (ext_low),
        .qualified (ext_qual)
    );

    rstseq_hold #(.MIN_HOLD(MIN_HOLD), .POR_CYC(POR_CYC)) u_hold (
        .clk      (clk),
        .rst      (rst),
        .src      (src),
        .ext_qual (ext_qual),
        .ext_low  (ext_low),
        .core_rst (core_rst),
        .drive_en (pin_drive_en)
    );

    rstseq_restart #(.START_DLY(START_DLY), .ADDR_W(ADDR_W), .VEC(VEC)) u_restart (
        .clk         (clk),
        .rst         (rst),
        .core_rst    (core_rst),
        .ds_lvl      (ds_lvl),
        .as_lvl      (as_lvl),
        .start_pulse (start_pulse),
        .start_addr  (start_addr)
    );

    // R2: a reset without an internal request needs a qualified pin run
    a_r2_ext_cause: assert property (@(posedge clk) disable iff (rst)
        ($rose(core_rst) && !$past(por_req || wdt_req || smr_req)) |-> $past(ext_qual));

    // R9: pin drive starts only from power-on or watchdog
    a_r9_drive_src: assert property (@(posedge clk) disable iff (rst)
        $rose(pin_drive_en) |-> $past(por_req || wdt_req));

endmodule

// File: tb/test_rstseq_top.sv
module test_rstseq_top;
    localparam int POR_T = 40;
    localparam int HOLD  = 18;
    localparam int DLY   = 6;
    localparam logic [11:0] VEC = 12'h00C;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ext_drv = 1'b1, por = 1'b0, wdt = 1'b0, smr = 1'b0;
    logic core_rst, drv_en, ds, as_l, pulse;
    logic [11:0] addr;
    logic ext_pin;

    int checks = 0, fails = 0;
    bit done = 0;
    logic prev_core = 1'b0, prev_as = 1'b1;
    logic [11:0] addr_exp = '0;

    assign ext_pin = ext_drv & ~drv_en;

    always #4 clk = ~clk;

    rstseq_top #(.POR_CYC(POR_T), .MIN_HOLD(HOLD), .START_DLY(DLY)) i_rstseq_top (
        .clk(clk), .rst(rst), .ext_rst_n(ext_pin), .por_req(por), .wdt_req(wdt),
        .smr_req(smr), .core_rst(core_rst), .pin_drive_en(drv_en), .ds_lvl(ds),
        .as_lvl(as_l), .start_pulse(pulse), .start_addr(addr)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic idle_outputs(input string tag);
        chk(core_rst == 0, {tag, " core_rst"}, core_rst, 0);
        chk(drv_en == 0,   {tag, " drive"}, drv_en, 0);
        chk(ds == 1,       {tag, " ds"}, ds, 1);
        chk(as_l == 1,     {tag, " as"}, as_l, 1);
        chk(pulse == 0,    {tag, " pulse"}, pulse, 0);
        chk(addr == 0,     {tag, " addr"}, addr, 0);
    endtask

    // kind: 0 pin pulse of k edges, 1 smr, 2 por, 3 wdt, 4 smr twice
    task automatic run_case(input int kind, input int k);
        int first_hi = -1, last_hi = -1, rises = 0, drv_first = -1, drv_last = -1;
        int pulse_i = -1, pulses = 0;
        int e_first, e_last, e_pulse, e_df, e_dl, e_rises, d;
        logic exp_as;
        case (kind)
            0: ext_drv = 1'b0;
            1, 4: smr = 1'b1;
            2: por = 1'b1;
            default: wdt = 1'b1;
        endcase
        for (int i = 1; i <= 80; i++) begin
            @(negedge clk);
            if (core_rst) begin
                if (!prev_core) rises++;
                if (first_hi < 0) first_hi = i;
                last_hi = i;
            end
            if (drv_en) begin
                if (drv_first < 0) drv_first = i;
                drv_last = i;
            end
            if (pulse) begin
                pulses++;
                if (pulse_i < 0) pulse_i = i;
            end
            chk(ds == !core_rst, "R4 ds level", ds, !core_rst);
            exp_as = core_rst ? (prev_core ? !prev_as : 1'b0) : 1'b1;
            chk(as_l == exp_as, "R5 as level", as_l, exp_as);
            if (core_rst) addr_exp = '0;
            else if (pulse) addr_exp = VEC;
            chk(addr == addr_exp, "R7 start_addr", addr, addr_exp);
            prev_core = core_rst;
            prev_as   = as_l;
            if (kind == 0 && i == k) ext_drv = 1'b1;
            if (kind != 0 && i == 1) begin por = 0; wdt = 0; smr = 0; end
            if (kind == 4 && i == 9)  smr = 1'b1;
            if (kind == 4 && i == 10) smr = 1'b0;
        end
        e_df = -1; e_dl = -1; e_rises = 1;
        case (kind)
            0: begin
                d = (k - 4 > HOLD) ? k - 4 : HOLD;
                e_first = 7; e_last = 6 + d; e_pulse = 13 + d;
            end
            1: begin e_first = 1; e_last = HOLD; e_pulse = HOLD + 7; end
            4: begin e_first = 1; e_last = 9 + HOLD; e_pulse = 16 + HOLD; end
            default: begin
                d = (POR_T > HOLD) ? POR_T : HOLD;
                e_first = 1; e_last = d; e_pulse = d + 7; e_df = 1; e_dl = POR_T;
            end
        endcase
        if (kind == 0 && k < 4) begin
            chk(rises == 0,  "R1 glitch rejected", rises, 0);
            chk(pulses == 0, "R1 no start pulse", pulses, 0);
            chk(drv_first == -1, "R1 no drive", drv_first, -1);
        end else begin
            chk(rises == e_rises,     "R10 single reset", rises, e_rises);
            chk(first_hi == e_first, (kind == 0) ? "R2 latch cycle" : "R8 R9 entry cycle", first_hi, e_first);
            chk(last_hi == e_last,   (kind == 0) ? "R3 reset length" : (kind == 4) ? "R11 restart hold" : "R8 R9 reset length", last_hi, e_last);
            chk(pulse_i == e_pulse,  "R6 start delay", pulse_i, e_pulse);
            chk(pulses == 1,         "R6 one pulse", pulses, 1);
            chk(drv_first == e_df,   (kind >= 2 && kind <= 3) ? "R8 drive start" : "R9 no drive", drv_first, e_df);
            chk(drv_last == e_dl,    "R8 drive length", drv_last, e_dl);
            chk(addr == VEC,         "R7 vector held", addr, VEC);
        end
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        idle_outputs("R12 held in rst");
        rst = 1'b0;
        repeat (10) @(negedge clk);
        idle_outputs("R12 idle after rst");
        for (int k = 1; k <= 30; k++) run_case(0, k);
        run_case(1, 0);
        run_case(2, 0);
        run_case(3, 0);
        run_case(4, 0);
        // R12: rst in the middle of a pin reset returns all outputs to idle
        ext_drv = 1'b0;
        repeat (10) @(negedge clk);
        chk(core_rst == 1, "R12 precondition in reset", core_rst, 1);
        rst = 1'b1;
        @(negedge clk);
        idle_outputs("R12 mid-reset rst");
        ext_drv = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        prev_core = 1'b0; prev_as = 1'b1; addr_exp = '0;
        repeat (10) @(negedge clk);
        idle_outputs("R12 quiet after rst");
        run_case(0, 4);
        done = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule